// File: doc/BRIEF.md
# E1 Sa-Bit Serial Link Interface

This block gives external serial logic access to the five national-use bits (Sa4 through Sa8) that timeslot 0 carries in every E1 frame without the alignment word. The block runs one bit per clock cycle. Each direction keeps its own position within the 512-bit double frame. A sync pulse marks bit 1 of timeslot 0 of the alignment frame, so bits 4 to 8 of timeslot 0 of the following non-alignment frame fall on double-frame positions 259 to 263. Position 0 is the cycle carrying the sync pulse. Each selected bit therefore recurs once every 250 us.

On the receive side the recovered stream is re-timed onto a link data output. A gated link clock is high only in the cycles where that output carries a Sa bit whose receive select is set. With one select set, the clock runs at 4 kHz. With all five set, it runs at 20 kHz. On the transmit side a demand clock asks external logic for one bit, one cycle before each selected Sa position. The block captures the link input in the Sa cycle and substitutes it into the outgoing stream. Unselected positions carry the normal transmit source unchanged. Frame search, CRC-4 and any HDLC handling are outside the block.

Top module: `e1_sa_link`

## Requirements
- R1: While `rst` is high, `rxLinkClk`, `rxLinkData`, `txLinkClk` and `txOut` are all low after the next clock edge, whatever the other inputs do.
- R2: Select bit i (i = 0..4) of `rxSel` or `txSel` enables Sa(4+i). Sa(4+i) occupies double-frame position 259+i, where position 0 is the cycle in which the sync input is high.
- R3: `rxLinkClk` is high in exactly the cycle after the receive position equals a selected Sa position, and is low in every other cycle. Over one double frame it pulses once per set bit of `rxSel`.
- R4: `rxLinkData` always equals the `rxData` value of the previous cycle, so it carries the whole recovered stream bit for bit.
- R5: `txLinkClk` is high in the cycle immediately before the transmit position reaches a selected Sa position. Over one double frame it pulses once per set bit of `txSel`.
- R6: In a cycle whose transmit position is a selected Sa position, `txLinkData` is captured, and it appears on `txOut` one cycle later.
- R7: In every other cycle, `txOut` equals the `txData` value of the previous cycle.
- R8: A sync pulse forces its direction's position to 0 in that same cycle, even when the old count would have landed on a selected Sa position. The Sa bit that would have landed there is neither extracted nor inserted.
- R9: The receive and transmit directions keep separate positions, syncs and selects, and neither affects the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one E1 bit per cycle |
| rst | input | 1 | Synchronous reset, active high |
| rxSel | input | SA_COUNT | Receive selects, bit 0 = Sa4 .. bit 4 = Sa8 |
| rxData | input | 1 | Recovered receive stream |
| rxSync | input | 1 | Receive double-frame start pulse |
| rxLinkClk | output | 1 | Gated receive link clock |
| rxLinkData | output | 1 | Re-timed receive stream |
| txSel | input | SA_COUNT | Transmit selects, bit 0 = Sa4 .. bit 4 = Sa8 |
| txData | input | 1 | Normal transmit source stream |
| txSync | input | 1 | Transmit double-frame start pulse |
| txLinkData | input | 1 | Link data to insert into selected Sa positions |
| txLinkClk | output | 1 | Transmit demand clock |
| txOut | output | 1 | Outgoing stream after substitution |

## Verification
Realignment and Sa handling can fall in the same cycle. This happens when a sync pulse arrives just as the free-running count would have reached a selected Sa position. The bench provokes it by pulsing both syncs when the old count stands at 259 with all selects set. It then confirms three things: no link clock pulse appears for the lost slot, the normal transmit bit goes out in that cycle, and exactly one full set of five pulses and insertions follows at the new positions. Receive and transmit activity also overlap, with different selects and offset syncs, to show that the two directions stay apart.

// File: rtl/e1sa_pkg.sv
`timescale 1ns/1ps
package e1sa_pkg;

  // Per-cycle strobes from the position control to the datapath.
  typedef struct packed {
    logic rxSaHit;   // receive bit of this cycle is a selected Sa bit
    logic txSaHit;   // transmit bit of this cycle takes link data
    logic txDemand;  // a selected Sa position follows two cycles on
  } saStrobe_t;

endpackage

// File: rtl/sa_pos_counter.sv
`timescale 1ns/1ps
// Double-frame bit position; a sync pulse makes the current cycle position 0.
module sa_pos_counter #(
  parameter int DF_BITS = 512,
  localparam int POS_W  = $clog2(DF_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync,
  output logic [POS_W-1:0] curPos
);

  logic [POS_W-1:0] cnt;

  always_comb curPos = sync ? '0 : cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (curPos == POS_W'(DF_BITS - 1))
      cnt <= '0;
    else
      cnt <= curPos + 1'b1;
  end

endmodule

// File: rtl/sa_ctrl.sv
`timescale 1ns/1ps
module sa_ctrl
  import e1sa_pkg::*;
#(
  parameter int SLOT_BITS = 8,
  parameter int SLOTS     = 32,
  parameter int SA_FIRST  = 4,
  parameter int SA_COUNT  = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rxSync,
  input  logic                txSync,
  input  logic [SA_COUNT-1:0] rxSel,
  input  logic [SA_COUNT-1:0] txSel,
  output saStrobe_t           strobe
);

  localparam int FRAME_BITS = SLOT_BITS * SLOTS;
  localparam int DF_BITS    = 2 * FRAME_BITS;
  localparam int POS_W      = $clog2(DF_BITS);
  localparam int SA_BASE    = FRAME_BITS + SA_FIRST - 1;
  localparam int LOOKAHEAD  = 2;

  logic [POS_W-1:0] rxPos;
  logic [POS_W-1:0] txPos;
  logic [POS_W-1:0] txAhead;

  sa_pos_counter #(.DF_BITS(DF_BITS)) rxCnt_i (
    .clk(clk), .rst(rst), .sync(rxSync), .curPos(rxPos)
  );

  sa_pos_counter #(.DF_BITS(DF_BITS)) txCnt_i (
    .clk(clk), .rst(rst), .sync(txSync), .curPos(txPos)
  );

  function automatic logic saHit(input logic [POS_W-1:0] pos,
                                 input logic [SA_COUNT-1:0] sel);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < SA_COUNT; i++)
      if (pos == POS_W'(SA_BASE + i)) hit = hit | sel[i];
    return hit;
  endfunction

  // Position two cycles ahead, wrapped inside the double frame.
  always_comb begin
    if (txPos >= POS_W'(DF_BITS - LOOKAHEAD))
      txAhead = txPos + POS_W'(LOOKAHEAD) - POS_W'(DF_BITS);
    else
      txAhead = txPos + POS_W'(LOOKAHEAD);
  end

  always_comb begin
    strobe.rxSaHit  = saHit(rxPos, rxSel);
    strobe.txSaHit  = saHit(txPos, txSel);
    strobe.txDemand = saHit(txAhead, txSel);
  end

endmodule

// File: rtl/sa_datapath.sv
`timescale 1ns/1ps
module sa_datapath
  import e1sa_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  saStrobe_t strobe,
  input  logic      rxData,
  input  logic      txData,
  input  logic      txLinkData,
  output logic      rxLinkClk,
  output logic      rxLinkData,
  output logic      txLinkClk,
  output logic      txOut
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rxLinkClk  <= 1'b0;
      rxLinkData <= 1'b0;
      txLinkClk  <= 1'b0;
      txOut      <= 1'b0;
    end else begin
      rxLinkClk  <= strobe.rxSaHit;
      rxLinkData <= rxData;
      txLinkClk  <= strobe.txDemand;
      txOut      <= strobe.txSaHit ? txLinkData : txData;
    end
  end

endmodule

// File: rtl/e1_sa_link.sv
`timescale 1ns/1ps
module e1_sa_link
  import e1sa_pkg::*;
#(
  parameter int SLOT_BITS = 8,
  parameter int SLOTS     = 32,
  parameter int SA_FIRST  = 4,
  parameter int SA_COUNT  = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SA_COUNT-1:0] rxSel,
  input  logic                rxData,
  input  logic                rxSync,
  output logic                rxLinkClk,
  output logic                rxLinkData,
  input  logic [SA_COUNT-1:0] txSel,
  input  logic                txData,
  input  logic                txSync,
  input  logic                txLinkData,
  output logic                txLinkClk,
  output logic                txOut
);

  saStrobe_t strobe;

  sa_ctrl #(
    .SLOT_BITS(SLOT_BITS), .SLOTS(SLOTS),
    .SA_FIRST(SA_FIRST), .SA_COUNT(SA_COUNT)
  ) ctrl_i (
    .clk(clk), .rst(rst),
    .rxSync(rxSync), .txSync(txSync),
    .rxSel(rxSel), .txSel(txSel),
    .strobe(strobe)
  );

  sa_datapath dp_i (
    .clk(clk), .rst(rst), .strobe(strobe),
    .rxData(rxData), .txData(txData), .txLinkData(txLinkData),
    .rxLinkClk(rxLinkClk), .rxLinkData(rxLinkData),
    .txLinkClk(txLinkClk), .txOut(txOut)
  );

endmodule

// File: rtl/e1_sa_link_chk.sv
`timescale 1ns/1ps
module e1_sa_link_chk #(
  parameter int SA_COUNT = 5
) (
  input logic                clk,
  input logic                rst,
  input logic [SA_COUNT-1:0] rxSel,
  input logic                rxData,
  input logic                rxSync,
  input logic                rxLinkClk,
  input logic                rxLinkData,
  input logic [SA_COUNT-1:0] txSel,
  input logic                txData,
  input logic                txSync,
  input logic                txLinkData,
  input logic                txLinkClk,
  input logic                txOut
);

  p_rx_follow_r4: assert property (@(posedge clk) disable iff (rst)
    !rst |=> rxLinkData == $past(rxData));

  p_rx_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    rxSel == '0 |=> !rxLinkClk);

  p_tx_nodemand_r5: assert property (@(posedge clk) disable iff (rst)
    txSel == '0 |=> !txLinkClk);

  p_tx_pass_r7: assert property (@(posedge clk) disable iff (rst)
    txSel == '0 |=> txOut == $past(txData));

  p_rx_sync_pos0_r8: assert property (@(posedge clk) disable iff (rst)
    rxSync |=> !rxLinkClk);

  p_tx_sync_pos0_r8: assert property (@(posedge clk) disable iff (rst)
    txSync |=> !txLinkClk);

  // Demand, then an undisturbed Sa cycle: the captured link bit goes out.
  p_tx_insert_r6: assert property (@(posedge clk) disable iff (rst)
    (txLinkClk && !txSync && $stable(txSel)) ##1 (!txSync && $stable(txSel))
      |=> txOut == $past(txLinkData));

endmodule

bind e1_sa_link e1_sa_link_chk #(.SA_COUNT(SA_COUNT)) chk_i (
  .clk(clk), .rst(rst),
  .rxSel(rxSel), .rxData(rxData), .rxSync(rxSync),
  .rxLinkClk(rxLinkClk), .rxLinkData(rxLinkData),
  .txSel(txSel), .txData(txData), .txSync(txSync),
  .txLinkData(txLinkData), .txLinkClk(txLinkClk), .txOut(txOut)
);

// File: tb/e1_sa_link_tb.sv
`timescale 1ns/1ps
module e1_sa_link_tb_top;

  localparam int DF = 512;
  localparam int SA0 = 259;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] rxSel = '0, txSel = '0;
  logic       rxData = 1'b0, rxSync = 1'b0;
  logic       txData = 1'b0, txSync = 1'b0, txLinkData = 1'b0;
  logic       rxLinkClk, rxLinkData, txLinkClk, txOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [4:0] rxSelNext = '0, txSelNext = '0;
  int  rxPos = DF - 1, txPos = DF - 1;
  int  pRxPos, pTxPos;
  logic [4:0] pRxSel, pTxSel;
  logic pRxData, pTxData, pTxLink;
  bit  havePrev = 1'b0;
  int  rxPulses = 0, txDemands = 0;

  always #10 clk = ~clk;

  e1_sa_link dut_i (
    .clk(clk), .rst(rst),
    .rxSel(rxSel), .rxData(rxData), .rxSync(rxSync),
    .rxLinkClk(rxLinkClk), .rxLinkData(rxLinkData),
    .txSel(txSel), .txData(txData), .txSync(txSync),
    .txLinkData(txLinkData), .txLinkClk(txLinkClk), .txOut(txOut)
  );

  // R2: Sa(4+i) sits at position 259+i when select bit i is set.
  function automatic bit isSa(input int pos, input logic [4:0] sel);
    if (pos >= SA0 && pos <= SA0 + 4) return sel[pos - SA0];
    return 1'b0;
  endfunction

  task automatic check1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic checkCount(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One bit cycle: judge outputs of the previous cycle, then drive the next.
  task automatic step(input bit rs, input bit ts);
    @(negedge clk);
    if (havePrev) begin
      check1("R3 rx link clock", rxLinkClk, isSa(pRxPos, pRxSel));
      check1("R4 rx link data", rxLinkData, pRxData);
      check1("R5 tx demand clock", txLinkClk, isSa((pTxPos + 2) % DF, pTxSel));
      if (isSa(pTxPos, pTxSel))
        check1("R6 tx insertion", txOut, pTxLink);
      else
        check1("R7 tx pass-through", txOut, pTxData);
      if (rxLinkClk === 1'b1) rxPulses++;
      if (txLinkClk === 1'b1) txDemands++;
    end
    rst        = 1'b0;
    rxSel      = rxSelNext;
    txSel      = txSelNext;
    rxSync     = rs;
    txSync     = ts;
    rxData     = 1'($urandom_range(0, 1));
    txData     = 1'($urandom_range(0, 1));
    txLinkData = 1'($urandom_range(0, 1));
    rxPos   = rs ? 0 : (rxPos + 1) % DF;
    txPos   = ts ? 0 : (txPos + 1) % DF;
    pRxPos  = rxPos;   pTxPos  = txPos;
    pRxSel  = rxSel;   pTxSel  = txSel;
    pRxData = rxData;  pTxData = txData;  pTxLink = txLinkData;
    havePrev = 1'b1;
  endtask

  task automatic test_reset();
    rst = 1'b1;
    rxSel = '1; txSel = '1; rxData = 1'b1; txData = 1'b1; txLinkData = 1'b1;
    rxSync = 1'b1; txSync = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check1("R1 reset rxLinkClk", rxLinkClk, 1'b0);
      check1("R1 reset rxLinkData", rxLinkData, 1'b0);
      check1("R1 reset txLinkClk", txLinkClk, 1'b0);
      check1("R1 reset txOut", txOut, 1'b0);
    end
  endtask

  // R2 R3 R4: every receive select combination over one double frame.
  task automatic test_rx_masks();
    txSelNext = '0;
    for (int m = 0; m < 32; m++) begin
      rxSelNext = 5'(m);
      rxPulses = 0;
      step(1'b1, 1'b0);
      for (int k = 1; k < DF; k++) step(1'b0, 1'b0);
      checkCount("R3 rx pulses per double frame", rxPulses, $countones(5'(m)));
    end
  endtask

  // R5 R6 R7: every transmit select combination over one double frame.
  task automatic test_tx_masks();
    rxSelNext = '0;
    for (int m = 0; m < 32; m++) begin
      txSelNext = 5'(m);
      txDemands = 0;
      step(1'b0, 1'b1);
      for (int k = 1; k < DF; k++) step(1'b0, 1'b0);
      checkCount("R5 tx demands per double frame", txDemands, $countones(5'(m)));
    end
  endtask

  // R8: resync lands exactly where the old count would reach Sa4.
  task automatic test_resync_collision();
    rxSelNext = '1; txSelNext = '1;
    step(1'b1, 1'b1);
    for (int k = 1; k < SA0; k++) step(1'b0, 1'b0);
    rxPulses = 0;
    step(1'b1, 1'b1);
    @(negedge clk);
    check1("R8 no rx pulse at collided slot", rxLinkClk, 1'b0);
    for (int k = 1; k < DF; k++) step(1'b0, 1'b0);
    checkCount("R8 rx pulses after resync", rxPulses, 5);
  endtask

  // R9: different selects and offset syncs on the two directions.
  task automatic test_independent();
    rxSelNext = 5'b10101; txSelNext = 5'b01010;
    rxPulses = 0;
    step(1'b1, 1'b0);
    for (int k = 1; k < 100; k++) step(1'b0, 1'b0);
    txDemands = 0;
    step(1'b0, 1'b1);
    for (int k = 1; k < 600; k++) step(1'b0, 1'b0);
    checkCount("R9 rx pulses with tx offset", rxPulses, 3);
    checkCount("R9 tx demands with rx offset", txDemands, 2);
  endtask

  initial begin
    test_reset();
    test_rx_masks();
    test_tx_masks();
    test_resync_collision();
    test_independent();
    step(1'b0, 1'b0);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #3ms;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule